// File: doc/BRIEF.md
# Serial Frame Start Gating Controller

This block decides, bit clock by bit clock, when a transparent (unframed) serial receiver and transmitter may move data. The receive side is opened by a carrier-detect line and the transmit side by a clear-to-send line. The block itself drives request-to-send when the transmitter has data waiting. It produces a per-bit enable for an external receive shifter and one for an external transmit shifter. It also produces start-of-frame and end-of-frame strobes for each side and a flag that tells the transmit shifter to send its first bit as zero.

Each handshake line has its own mode bit. In pulse mode a single assertion starts a stream that never stops. In envelope mode the line must stay high for the whole frame. Each line is also sampled either directly, for a line that is already synchronous to the bit clock, or through a multi-stage synchronizer, for a line from another clock domain. The gating is active only when the sync-length selector is zero. Any other selector value, and any change of the configuration inputs, puts both sides back to idle.

Top module: `frame_start_gate`

## Requirements
- R1: After reset every output (`rx_bit_en`, `rx_sof`, `rx_eof`, `tx_bit_en`, `tx_sof`, `tx_eof`, `tx_zero_first`, `rts_line`) is 0.
- R2: Gating is active only while `cfg_sync_sel` equals 2'b00. For any other value, every enable, strobe and `rts_line` stays 0 from the next clock edge on, and the handshake lines have no effect.
- R3: With direct sampling (`cfg_rx_async`=0) `rx_bit_en` rises at the first clock edge that sees `cd_line` high. With synchronized sampling (`cfg_rx_async`=1) it rises at the third edge.
- R4: With `cfg_rx_env`=0 (pulse), once `rx_bit_en` is high it stays high when `cd_line` falls, and `rx_eof` is never pulsed.
- R5: With `cfg_rx_env`=1 (envelope), the edge that sees `cd_line` low during a frame drops `rx_bit_en`, and `rx_eof` is high for exactly that next cycle.
- R6: In receive envelope mode a new frame starts only if the sampled `cd_line` was low for at least 3 clocks since the previous frame. A shorter gap is ignored, and the line must fall again and stay low for 3 clocks.
- R7: `rx_sof` and `tx_sof` are high for one cycle, and only on the first cycle of their side's enable.
- R8: The edge that sees `tx_pending` high while idle raises `rts_line`. With direct sampling, `tx_bit_en` rises at the edge that sees `cts_line` high while `rts_line` is high. `tx_bit_en` is never high without `rts_line`.
- R9: `tx_zero_first` is high on the first enabled transmit bit exactly when `cts_line` was seen low while `rts_line` was being raised or while waiting. In envelope mode (`cfg_tx_env`=1) this applies to every frame.
- R10: In transmit envelope mode, a frame ends when `tx_last` is high on an enabled bit or when `cts_line` is seen low. `tx_bit_en` then drops, `tx_eof` is high for one cycle, and `rts_line` stays high for exactly one more cycle before falling. If both causes arrive together, there is only one end.
- R11: In transmit pulse mode (`cfg_tx_env`=0), `cts_line` deassertion, `tx_last` and `tx_pending` have no effect once the stream runs: `tx_bit_en` and `rts_line` stay high and `tx_eof` stays 0.
- R12: Any change of the configuration inputs returns both sides to idle at the next clock edge, with `rx_bit_en`, `tx_bit_en` and `rts_line` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sync_sel | input | 2 | Sync-length selector; gating only when 2'b00 |
| cfg_rx_env | input | 1 | Carrier-detect mode: 1 envelope, 0 pulse |
| cfg_tx_env | input | 1 | Clear-to-send mode: 1 envelope, 0 pulse |
| cfg_rx_async | input | 1 | 1 synchronizes carrier detect, 0 samples it directly |
| cfg_tx_async | input | 1 | 1 synchronizes clear-to-send, 0 samples it directly |
| cd_line | input | 1 | Carrier detect, active high |
| cts_line | input | 1 | Clear to send, active high |
| tx_pending | input | 1 | Transmitter has data queued |
| tx_last | input | 1 | Current enabled transmit bit is the last of the frame |
| rx_bit_en | output | 1 | Receive shifter bit enable |
| rx_sof | output | 1 | Receive start-of-frame strobe |
| rx_eof | output | 1 | Receive end-of-frame strobe |
| tx_bit_en | output | 1 | Transmit shifter bit enable |
| tx_sof | output | 1 | Transmit start-of-frame strobe |
| tx_eof | output | 1 | Transmit end-of-frame strobe |
| tx_zero_first | output | 1 | Send the current (first) transmit bit as 0 |
| rts_line | output | 1 | Request to send, active high |

## Verification
Two ways of ending a transmit envelope frame can fall in the same cycle: the transmitter marks its last bit while clear-to-send drops. The bench drives `tx_last` high and `cts_line` low before the same edge. It then requires exactly one `tx_eof` cycle and a single one-cycle request-to-send tail, not a doubled or stretched end. A second collision is the carrier-detect rise that arrives exactly as the low-gap count reaches its minimum. That case is judged against a rise one clock earlier, which must be ignored.

// File: rtl/fsg_pkg.sv
// fsg_pkg: shared state types and constants for the frame start gating controller.
// Assumes: single bit-clock domain for all state.
package fsg_pkg;

    // Width of the sync-length selector field.
    localparam int SEL_W = 2;

    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_WAIT  = 2'd1,
        TX_RUN   = 2'd2,
        TX_DRAIN = 2'd3
    } tx_state_t;

endpackage

// File: rtl/fsg_line_sampler.sv
// fsg_line_sampler: brings one handshake line into the bit-clock domain.
// With async_sel=1 the line passes through STAGES flops. With async_sel=0 the
// line is assumed synchronous to clk and is passed straight through.
// Assumes: STAGES >= 1.
module fsg_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_sel,
    input  logic line_in,
    output logic line_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= line_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Pick the synchronized or the direct view of the line.
    always_comb begin
        line_out = async_sel ? chain[STAGES-1] : line_in;
    end

endmodule

// File: rtl/fsg_rx_gate.sv
// fsg_rx_gate: receive-side frame gating driven by the sampled carrier-detect line.
// Pulse mode: the first high level starts an endless stream.
// Envelope mode: the frame lasts while the line is high. A new frame needs the
// line low for MIN_GAP clocks first.
// Assumes: line is already in the clk domain. clear forces idle without an end strobe.
module fsg_rx_gate
    import fsg_pkg::*;
#(
    parameter int MIN_GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic env_mode,
    input  logic line,
    output logic bit_en,
    output logic sof,
    output logic eof
);

    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);

    rx_state_t        state, nxt;
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_ok;
    logic             start_ok;

    // Decide whether the line may open a frame now.
    always_comb begin
        gap_ok   = (gap_cnt >= GAP_MAX);
        start_ok = line && (!env_mode || gap_ok);
    end

    // Next-state logic for the receive gate.
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE: if (!clear && start_ok) nxt = RX_RUN;
            RX_RUN: begin
                if (clear)                 nxt = RX_IDLE;
                else if (env_mode && !line) nxt = RX_IDLE;
            end
            default: nxt = RX_IDLE;
        endcase
    end

    // State register and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sof   <= 1'b0;
            eof   <= 1'b0;
        end else begin
            state <= nxt;
            sof   <= (state == RX_IDLE) && (nxt == RX_RUN);
            eof   <= (state == RX_RUN) && (nxt == RX_IDLE) && !clear;
        end
    end

    // Count the low clocks of the line, saturating at the minimum gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= GAP_MAX;
        end else if (line) begin
            gap_cnt <= '0;
        end else if (!gap_ok) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // The enable follows the running state.
    always_comb begin
        bit_en = (state == RX_RUN);
    end

endmodule

// File: rtl/fsg_tx_gate.sv
// fsg_tx_gate: transmit-side gating. Raises request-to-send for queued data and
// waits for the sampled clear-to-send line. In envelope mode it ends each frame on
// the last bit or on clear-to-send loss and then holds request-to-send one more clock.
// It also flags a forced-zero first bit when request-to-send led clear-to-send.
// Assumes: line is already in the clk domain. clear forces idle at once.
module fsg_tx_gate
    import fsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic env_mode,
    input  logic line,
    input  logic pending,
    input  logic last,
    output logic bit_en,
    output logic sof,
    output logic eof,
    output logic zero_first,
    output logic rts
);

    tx_state_t state, nxt;
    logic      rts_led;

    // Next-state logic for the transmit gate.
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (!clear && pending) nxt = TX_WAIT;
            TX_WAIT: begin
                if (clear)     nxt = TX_IDLE;
                else if (line) nxt = TX_RUN;
            end
            TX_RUN: begin
                if (clear)                          nxt = TX_IDLE;
                else if (env_mode && (!line || last)) nxt = TX_DRAIN;
            end
            TX_DRAIN: nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    // State register and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            sof        <= 1'b0;
            eof        <= 1'b0;
            zero_first <= 1'b0;
        end else begin
            state      <= nxt;
            sof        <= (state != TX_RUN) && (nxt == TX_RUN);
            eof        <= (state == TX_RUN) && (nxt == TX_DRAIN);
            zero_first <= (state == TX_WAIT) && (nxt == TX_RUN) && rts_led;
        end
    end

    // Remember whether clear-to-send was low while request-to-send was up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_led <= 1'b0;
        end else if (state == TX_IDLE) begin
            rts_led <= !line;
        end else if (state == TX_WAIT) begin
            rts_led <= rts_led || !line;
        end
    end

    // Decode the enable and request-to-send from the state.
    always_comb begin
        bit_en = (state == TX_RUN);
        rts    = (state == TX_WAIT) || (state == TX_RUN) || (state == TX_DRAIN);
    end

endmodule

// File: rtl/frame_start_gate.sv
// frame_start_gate: top of the serial frame start gating controller. Samples both
// handshake lines, holds both gates idle unless the sync-length selector is zero, and
// returns them to idle for a clock whenever any configuration input changes.
// Assumes: one bit clock for everything; configuration is quasi-static.
module frame_start_gate
    import fsg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_GAP     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] cfg_sync_sel,
    input  logic             cfg_rx_env,
    input  logic             cfg_tx_env,
    input  logic             cfg_rx_async,
    input  logic             cfg_tx_async,
    input  logic             cd_line,
    input  logic             cts_line,
    input  logic             tx_pending,
    input  logic             tx_last,
    output logic             rx_bit_en,
    output logic             rx_sof,
    output logic             rx_eof,
    output logic             tx_bit_en,
    output logic             tx_sof,
    output logic             tx_eof,
    output logic             tx_zero_first,
    output logic             rts_line
);

    localparam int CFG_W = SEL_W + 4;

    logic [CFG_W-1:0] cfg_vec, cfg_q;
    logic             kill;
    logic             cd_s, cts_s;

    // Gather the configuration into one word for change detection.
    always_comb begin
        cfg_vec = {cfg_sync_sel, cfg_rx_env, cfg_tx_env, cfg_rx_async, cfg_tx_async};
        kill    = (cfg_vec != cfg_q) || (cfg_sync_sel != '0);
    end

    // Keep last cycle's configuration to spot mode changes.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_vec;
    end

    fsg_line_sampler #(.STAGES(SYNC_STAGES)) i_cd_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_sel(cfg_rx_async),
        .line_in  (cd_line),
        .line_out (cd_s)
    );

    fsg_line_sampler #(.STAGES(SYNC_STAGES)) i_cts_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_sel(cfg_tx_async),
        .line_in  (cts_line),
        .line_out (cts_s)
    );

    fsg_rx_gate #(.MIN_GAP(MIN_GAP)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (kill),
        .env_mode(cfg_rx_env),
        .line    (cd_s),
        .bit_en  (rx_bit_en),
        .sof     (rx_sof),
        .eof     (rx_eof)
    );

    fsg_tx_gate i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (kill),
        .env_mode  (cfg_tx_env),
        .line      (cts_s),
        .pending   (tx_pending),
        .last      (tx_last),
        .bit_en    (tx_bit_en),
        .sof       (tx_sof),
        .eof       (tx_eof),
        .zero_first(tx_zero_first),
        .rts       (rts_line)
    );

endmodule

// File: rtl/fsg_frame_gate_chk.sv
// fsg_frame_gate_chk: protocol assertions for frame_start_gate, attached by bind.
// Assumes: kill is the top's internal idle-forcing condition.
module fsg_frame_gate_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] cfg_sync_sel,
    input logic             cfg_rx_env,
    input logic             cfg_tx_env,
    input logic             kill,
    input logic             rx_bit_en,
    input logic             rx_sof,
    input logic             rx_eof,
    input logic             tx_bit_en,
    input logic             tx_sof,
    input logic             tx_zero_first,
    input logic             rts_line
);

    p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sync_sel != '0) |=> (!rx_bit_en && !tx_bit_en && !rts_line));

    p_rx_pulse_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rx_env && rx_bit_en && !kill) |=> rx_bit_en);

    p_rx_eof_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eof |-> (!rx_bit_en && $past(rx_bit_en)));

    p_rx_sof_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sof |-> (rx_bit_en && !$past(rx_bit_en)));

    p_tx_sof_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |-> (tx_bit_en && !$past(tx_bit_en)));

    p_tx_needs_rts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_en |-> rts_line);

    p_zero_on_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_zero_first |-> tx_sof);

    p_rts_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_bit_en) && !tx_bit_en && !$past(kill)) |-> rts_line);

    p_tx_pulse_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_tx_env && tx_bit_en && !kill) |=> tx_bit_en);

endmodule

bind frame_start_gate fsg_frame_gate_chk #(.SEL_W(fsg_pkg::SEL_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sync_sel (cfg_sync_sel),
    .cfg_rx_env   (cfg_rx_env),
    .cfg_tx_env   (cfg_tx_env),
    .kill         (kill),
    .rx_bit_en    (rx_bit_en),
    .rx_sof       (rx_sof),
    .rx_eof       (rx_eof),
    .tx_bit_en    (tx_bit_en),
    .tx_sof       (tx_sof),
    .tx_zero_first(tx_zero_first),
    .rts_line     (rts_line)
);

// File: tb/test_frame_start_gate.sv
// test_frame_start_gate: directed bench, one task per scenario. Inputs change and
// outputs are sampled 2 ns after each rising edge.
module test_frame_start_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_sync_sel = 2'b00;
    logic       cfg_rx_env = 1'b1, cfg_tx_env = 1'b1;
    logic       cfg_rx_async = 1'b0, cfg_tx_async = 1'b0;
    logic       cd_line = 1'b0, cts_line = 1'b0, tx_pending = 1'b0, tx_last = 1'b0;
    logic       rx_bit_en, rx_sof, rx_eof, tx_bit_en, tx_sof, tx_eof, tx_zero_first, rts_line;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    frame_start_gate i_frame_start_gate (
        .clk(clk), .rst_n(rst_n), .cfg_sync_sel(cfg_sync_sel),
        .cfg_rx_env(cfg_rx_env), .cfg_tx_env(cfg_tx_env),
        .cfg_rx_async(cfg_rx_async), .cfg_tx_async(cfg_tx_async),
        .cd_line(cd_line), .cts_line(cts_line), .tx_pending(tx_pending), .tx_last(tx_last),
        .rx_bit_en(rx_bit_en), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .tx_bit_en(tx_bit_en), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .tx_zero_first(tx_zero_first), .rts_line(rts_line)
    );

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(logic got, logic exp, string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic set_cfg(logic [1:0] sel, logic rxe, logic txe, logic rxa, logic txa);
        cfg_sync_sel = sel; cfg_rx_env = rxe; cfg_tx_env = txe;
        cfg_rx_async = rxa; cfg_tx_async = txa;
    endtask

    task automatic do_reset();
        cd_line = 0; cts_line = 0; tx_pending = 0; tx_last = 0;
        rst_n = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    task automatic t_reset();
        set_cfg(2'b00, 1, 1, 0, 0);
        do_reset();
        chk(rx_bit_en | rx_sof | rx_eof, 0, "R1 rx outputs after reset");
        chk(tx_bit_en | tx_sof | tx_eof | tx_zero_first, 0, "R1 tx outputs after reset");
        chk(rts_line, 0, "R1 rts after reset");
    endtask

    task automatic t_rx_env_sync();
        set_cfg(2'b00, 1, 1, 0, 0);
        do_reset();
        cd_line = 1; tick();
        chk(rx_bit_en, 1, "R3 direct sampling one edge");
        chk(rx_sof, 1, "R7 rx_sof on first bit");
        tick();
        chk(rx_sof, 0, "R7 rx_sof one cycle");
        chk(rx_bit_en, 1, "R5 enable while carrier high");
        cd_line = 0; tick();
        chk(rx_bit_en, 0, "R5 enable drops on carrier loss");
        chk(rx_eof, 1, "R5 rx_eof pulse");
        tick();
        chk(rx_eof, 0, "R5 rx_eof one cycle");
    endtask

    task automatic t_rx_async();
        set_cfg(2'b00, 1, 1, 1, 0);
        do_reset();
        cd_line = 1; tick(2);
        chk(rx_bit_en, 0, "R3 synchronized not yet at edge two");
        tick();
        chk(rx_bit_en, 1, "R3 synchronized at edge three");
    endtask

    task automatic t_rx_pulse();
        set_cfg(2'b00, 0, 1, 0, 0);
        do_reset();
        cd_line = 1; tick();
        chk(rx_bit_en, 1, "R4 pulse start");
        cd_line = 0; tick(2);
        chk(rx_bit_en, 1, "R4 pulse keeps running after carrier loss");
        chk(rx_eof, 0, "R4 no rx_eof in pulse mode");
    endtask

    task automatic t_rx_gap();
        set_cfg(2'b00, 1, 1, 0, 0);
        do_reset();
        cd_line = 1; tick(2);
        cd_line = 0; tick(2);
        cd_line = 1; tick();
        chk(rx_bit_en, 0, "R6 two-clock gap ignored");
        chk(rx_sof, 0, "R6 no sof after short gap");
        tick();
        chk(rx_bit_en, 0, "R6 still idle while carrier held");
        cd_line = 0; tick(3);
        cd_line = 1; tick();
        chk(rx_bit_en, 1, "R6 three-clock gap accepted");
        chk(rx_sof, 1, "R7 sof after valid gap");
    endtask

    task automatic t_tx_env();
        set_cfg(2'b00, 1, 1, 0, 0);
        do_reset();
        tx_pending = 1; tick();
        chk(rts_line, 1, "R8 rts raised on pending");
        chk(tx_bit_en, 0, "R8 no enable before cts");
        tick();
        chk(tx_bit_en, 0, "R8 waits for cts");
        cts_line = 1; tick();
        chk(tx_bit_en, 1, "R8 enable one edge after cts");
        chk(tx_sof, 1, "R7 tx_sof on first bit");
        chk(tx_zero_first, 1, "R9 zero first when rts led cts");
        tick();
        chk(tx_zero_first, 0, "R9 only first bit zeroed");
        tx_last = 1; tick();
        chk(tx_bit_en, 0, "R10 last bit ends frame");
        chk(tx_eof, 1, "R10 tx_eof on end");
        chk(rts_line, 1, "R10 rts held one clock");
        tx_last = 0; cts_line = 0; tick();
        chk(rts_line, 0, "R10 rts falls after tail");
        chk(tx_eof, 0, "R10 tx_eof one cycle");
        tick();
        chk(rts_line, 1, "R8 rts again for second frame");
        cts_line = 1; tick();
        chk(tx_zero_first, 1, "R9 every envelope frame zeroed");
        tx_pending = 0; cts_line = 0; tick();
        chk(tx_eof, 1, "R10 cts loss ends frame");
        chk(rts_line, 1, "R10 rts tail after cts loss");
        tick();
        chk(rts_line, 0, "R10 rts low after cts-loss tail");
    endtask

    task automatic t_tx_cts_first();
        set_cfg(2'b00, 1, 1, 0, 0);
        do_reset();
        cts_line = 1; tx_pending = 1; tick();
        chk(rts_line, 1, "R8 rts with cts already high");
        tick();
        chk(tx_bit_en, 1, "R8 start with cts already high");
        chk(tx_zero_first, 0, "R9 no zero when cts came first");
    endtask

    task automatic t_tx_pulse();
        set_cfg(2'b00, 1, 0, 0, 0);
        do_reset();
        tx_pending = 1; tick();
        cts_line = 1; tick();
        chk(tx_zero_first, 1, "R9 pulse first frame zeroed");
        cts_line = 0; tx_last = 1; tx_pending = 0; tick(2);
        chk(tx_bit_en, 1, "R11 pulse stream continues");
        chk(rts_line, 1, "R11 rts stays in pulse mode");
        chk(tx_eof, 0, "R11 no tx_eof in pulse mode");
        tx_last = 0;
    endtask

    task automatic t_gating_off();
        set_cfg(2'b01, 1, 1, 0, 0);
        do_reset();
        cd_line = 1; cts_line = 1; tx_pending = 1; tick(3);
        chk(rx_bit_en | rx_sof, 0, "R2 rx held idle for nonzero selector");
        chk(tx_bit_en | tx_sof, 0, "R2 tx held idle for nonzero selector");
        chk(rts_line, 0, "R2 rts held low for nonzero selector");
    endtask

    task automatic t_mode_change();
        set_cfg(2'b00, 1, 1, 0, 0);
        do_reset();
        cd_line = 1; cts_line = 1; tx_pending = 1; tick(2);
        chk(rx_bit_en, 1, "R12 rx running before change");
        chk(tx_bit_en, 1, "R12 tx running before change");
        cfg_rx_env = 0; tick();
        chk(rx_bit_en, 0, "R12 rx idle after mode change");
        chk(tx_bit_en, 0, "R12 tx idle after mode change");
        chk(rts_line, 0, "R12 rts low after mode change");
    endtask

    task automatic t_double_end();
        set_cfg(2'b00, 1, 1, 0, 0);
        do_reset();
        tx_pending = 1; cts_line = 1; tick(2);
        chk(tx_bit_en, 1, "R10 running before double end");
        tx_pending = 0; cts_line = 0; tx_last = 1; tick();
        chk(tx_eof, 1, "R10 single eof on coincident end");
        chk(rts_line, 1, "R10 tail on coincident end");
        tx_last = 0; tick();
        chk(tx_eof, 0, "R10 eof not doubled");
        chk(rts_line, 0, "R10 tail not stretched");
    endtask

    initial begin
        t_reset();
        t_rx_env_sync();
        t_rx_async();
        t_rx_pulse();
        t_rx_gap();
        t_tx_env();
        t_tx_cts_first();
        t_tx_pulse();
        t_gating_off();
        t_mode_change();
        t_double_end();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule